// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

This block is a watchdog timer on a small 32-bit register port. A 15-bit counter counts down by one on each pulse of a tick strobe; in normal use that pulse comes every 10 ms, so the longest period is about 327 seconds. Software keeps the system alive by writing a key word to the reload register. If it fails to do so, the block raises a one-cycle reset pulse, latches a timed-out status and starts the count again from the programmed period.

Every action that changes the timer's state needs a 16-bit key. A key is accepted only when bits 31:16 of the write word are zero. Stopping the timer takes two keyed writes to two different registers, and they must be consecutive writes in that order. An interrupt event is raised one tick before expiry. The interrupt output combines that event with a mask bit and a force bit. A debug-mode input freezes the count unless software has allowed the timer to run in debug mode.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is enabled, the period and count are both 6000, status reads 0x0000, the event, mask, force and debug-run bits are 0, and the reset and interrupt outputs are low.
- R2: Writing 0x0000FEED to offset 0x00 loads the count from the period register, and the next read of the count shows that value. Any other value written there leaves the count unchanged.
- R3: Offset 0x04 holds the period in bits 14:0. While the timer runs, each tick lowers the count by one. Offset 0x14 returns the count in bits 14:0. Bit 15 of that read is 1 in the cycle after the count changed and 0 otherwise.
- R4: A tick that arrives while the timer runs and the count is 1 or 0 is an expiry. In the next cycle the reset output is high for exactly one cycle, and the count has been loaded from the period.
- R5: A tick that takes the count from 2 to 1 sets the event bit, which is bit 0 at offset 0x20. Writing a word with bit 0 set to 0x20 clears the event bit. If a new event arrives in the same cycle, setting wins over clearing.
- R6: The interrupt output equals (event AND mask) OR force. The mask is bit 0 at offset 0x24 and the force is bit 0 at offset 0x28; both can be read back.
- R7: The timer stops only when 0x00002BAD is written to offset 0x08 and the very next write is 0x0000CAFE to offset 0x0C. A 0xCAFE write without that preceding write, or after another write in between, is ignored. Offset 0x0C reads 0x0000DABE while the timer is stopped and 0x00000000 while it is enabled. A stopped count ignores ticks.
- R8: Writing 0x0000ACED to offset 0x1C enables a stopped timer and leaves the count unchanged. Other values written there are ignored.
- R9: Offset 0x10 reads 0x0000CFE8 once an expiry has occurred and 0x00000000 otherwise. Writing 0x0000E8B4 clears it; any other value has no effect. An expiry in the same cycle as a clear leaves the status set.
- R10: At offset 0x18, bit 1 reads the debug-mode input and bit 0 is the writable debug-run bit. While debug mode is high and debug-run is 0, ticks do not change the count.
- R11: A valid reload write in the same cycle as a tick loads the period. That tick neither counts down, raises an event, nor causes an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle count strobe (nominally every 10 ms) |
| dbg_mode_i | input | 1 | High while the system is in debug mode |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| warn_irq_o | output | 1 | Early-warning interrupt |
| wdt_rst_o | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest cases to reach are the collisions inside a single cycle: a tick landing on the same edge as a reload write, a status clear or an event acknowledge. A spoiled stop sequence is also hard to reach, because some unrelated write has to fall between the two keyed writes. The bench programs periods of one to six ticks so that expiries and warnings come often. Its random operation stream issues a tick together with a register write on many cycles and mixes the two halves of the stop sequence with other writes. Directed cases first cover the lone second key, the interrupted sequence and a reload that coincides with a tick.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int BUS_W = 32;
  localparam int KEY_W = 16;

  localparam logic [7:0] OFF_RELOAD = 8'h00;
  localparam logic [7:0] OFF_PERIOD = 8'h04;
  localparam logic [7:0] OFF_LOCK1  = 8'h08;
  localparam logic [7:0] OFF_LOCK2  = 8'h0C;
  localparam logic [7:0] OFF_STATUS = 8'h10;
  localparam logic [7:0] OFF_COUNT  = 8'h14;
  localparam logic [7:0] OFF_DEBUG  = 8'h18;
  localparam logic [7:0] OFF_RESUME = 8'h1C;
  localparam logic [7:0] OFF_EVENT  = 8'h20;
  localparam logic [7:0] OFF_MASK   = 8'h24;
  localparam logic [7:0] OFF_FORCE  = 8'h28;

  localparam logic [KEY_W-1:0] KEY_RELOAD  = 16'hFEED;
  localparam logic [KEY_W-1:0] KEY_LOCK1   = 16'h2BAD;
  localparam logic [KEY_W-1:0] KEY_LOCK2   = 16'hCAFE;
  localparam logic [KEY_W-1:0] KEY_RESUME  = 16'hACED;
  localparam logic [KEY_W-1:0] KEY_CLRSTAT = 16'hE8B4;
  localparam logic [KEY_W-1:0] CODE_STOP   = 16'hDABE;
  localparam logic [KEY_W-1:0] CODE_EXPIRE = 16'hCFE8;

  // A key matches only with the upper half of the bus word zero.
  function automatic logic key_match(input logic [BUS_W-1:0] word,
                                     input logic [KEY_W-1:0] key);
    return word == {{(BUS_W-KEY_W){1'b0}}, key};
  endfunction

  // Widen a 16-bit code to the bus width.
  function automatic logic [BUS_W-1:0] code_word(input logic [KEY_W-1:0] code);
    return {{(BUS_W-KEY_W){1'b0}}, code};
  endfunction
endpackage

// File: rtl/kwdt_keys.sv
module kwdt_keys
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic              reload_hit,
  output logic              clrstat_hit,
  output logic              stop_hit,
  output logic              enabled,
  output logic              armed
);
  logic lock1_hit, resume_hit;

  always_comb begin
    reload_hit  = we && addr == OFF_RELOAD && key_match(wdata, KEY_RELOAD);
    lock1_hit   = we && addr == OFF_LOCK1  && key_match(wdata, KEY_LOCK1);
    stop_hit    = we && addr == OFF_LOCK2  && key_match(wdata, KEY_LOCK2) && armed;
    resume_hit  = we && addr == OFF_RESUME && key_match(wdata, KEY_RESUME);
    clrstat_hit = we && addr == OFF_STATUS && key_match(wdata, KEY_CLRSTAT);
  end

  // The first half of the stop sequence lives only until the next write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  armed <= 1'b0;
    else if (we) armed <= lock1_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          enabled <= 1'b1;
    else if (stop_hit)   enabled <= 1'b0;
    else if (resume_hit) enabled <= 1'b1;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 15,
  parameter int DEF_PERIOD = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             warn_evt,
  output logic             expire_evt,
  output logic             upd
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic step;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return v - ONE;
  endfunction

  always_comb begin
    step       = tick && run && !reload_req;
    expire_evt = step && cnt <= ONE;
    warn_evt   = step && cnt == TWO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RST_CNT;
      upd <= 1'b0;
    end else begin
      upd <= reload_req || step;
      if (reload_req || expire_evt) cnt <= period;
      else if (step)                cnt <= dec(cnt);
    end
  end
endmodule

// File: rtl/kwdt_irq.sv
module kwdt_irq
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  input  logic              warn_evt,
  output logic              evt_q,
  output logic              mask_q,
  output logic              force_q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q   <= 1'b0;
      mask_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (warn_evt)                                evt_q <= 1'b1;
      else if (we && addr == OFF_EVENT && wbit)    evt_q <= 1'b0;
      if (we && addr == OFF_MASK)  mask_q  <= wbit;
      if (we && addr == OFF_FORCE) force_q <= wbit;
    end
  end

  assign irq = (evt_q & mask_q) | force_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int DEF_PERIOD = 6000,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              dbg_mode_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              warn_irq_o,
  output logic              wdt_rst_o
);
  localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_PERIOD);
  localparam int PAD_PER = BUS_W - CNT_W;
  localparam int PAD_CNT = BUS_W - CNT_W - 1;

  logic             reload_hit, clrstat_hit, stop_hit, enabled, armed;
  logic             run, warn_evt, expire_evt, upd;
  logic [CNT_W-1:0] cnt, period;
  logic             timed_out, dbg_run;
  logic             evt_q, mask_q, force_q;

  kwdt_keys #(.ADDR_W(ADDR_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .we(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .reload_hit(reload_hit), .clrstat_hit(clrstat_hit),
    .stop_hit(stop_hit), .enabled(enabled), .armed(armed)
  );

  assign run = enabled && (!dbg_mode_i || dbg_run);

  kwdt_counter #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(run),
    .reload_req(reload_hit), .period(period), .cnt(cnt),
    .warn_evt(warn_evt), .expire_evt(expire_evt), .upd(upd)
  );

  kwdt_irq #(.ADDR_W(ADDR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .we(bus_we_i), .addr(bus_addr_i),
    .wbit(bus_wdata_i[0]), .warn_evt(warn_evt), .evt_q(evt_q),
    .mask_q(mask_q), .force_q(force_q), .irq(warn_irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period    <= RST_PERIOD;
      timed_out <= 1'b0;
      dbg_run   <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else begin
      wdt_rst_o <= expire_evt;
      if (expire_evt)       timed_out <= 1'b1;
      else if (clrstat_hit) timed_out <= 1'b0;
      if (bus_we_i && bus_addr_i == OFF_PERIOD) period  <= bus_wdata_i[CNT_W-1:0];
      if (bus_we_i && bus_addr_i == OFF_DEBUG)  dbg_run <= bus_wdata_i[0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_PERIOD: bus_rdata_o = {{PAD_PER{1'b0}}, period};
      OFF_LOCK2:  bus_rdata_o = enabled ? '0 : code_word(CODE_STOP);
      OFF_STATUS: bus_rdata_o = timed_out ? code_word(CODE_EXPIRE) : '0;
      OFF_COUNT:  bus_rdata_o = {{PAD_CNT{1'b0}}, upd, cnt};
      OFF_DEBUG:  bus_rdata_o = {{(BUS_W-2){1'b0}}, dbg_mode_i, dbg_run};
      OFF_EVENT:  bus_rdata_o = {{(BUS_W-1){1'b0}}, evt_q};
      OFF_MASK:   bus_rdata_o = {{(BUS_W-1){1'b0}}, mask_q};
      OFF_FORCE:  bus_rdata_o = {{(BUS_W-1){1'b0}}, force_q};
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             reload_hit,
  input logic             enabled,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             timed_out,
  input logic             force_q,
  input logic             warn_irq_o,
  input logic             wdt_rst_o
);
  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    reload_hit |=> cnt == $past(period)); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reload_hit) |=> cnt == $past(cnt)); // R7
  AST_STOP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(enabled) |-> $past(armed)); // R7
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_RST_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> timed_out); // R9
  AST_FORCE_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |-> warn_irq_o); // R6
endmodule

bind keyed_wdt kwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .reload_hit(reload_hit),
  .enabled(enabled), .armed(armed), .cnt(cnt), .period(period),
  .timed_out(timed_out), .force_q(force_q), .warn_irq_o(warn_irq_o),
  .wdt_rst_o(wdt_rst_o)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        dbg_mode_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        warn_irq_o, wdt_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  int m_cnt, m_period;
  bit m_en, m_armed, m_st, m_evt, m_mask, m_force, m_dbgrun, m_rst, m_upd;

  always #4 clk = ~clk;

  keyed_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_mode_i(dbg_mode_i),
    .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .warn_irq_o(warn_irq_o), .wdt_rst_o(wdt_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr_i = a;
    #1;
    v = bus_rdata_o;
  endtask

  // Model of one clock edge, written from the requirements.
  task automatic model(input bit t, input bit w, input logic [7:0] a, input logic [31:0] d);
    bit run, feed, ex, wn;
    run  = m_en && (!dbg_mode_i || m_dbgrun);
    feed = w && a == 8'h00 && d == 32'hFEED;
    ex = 0; wn = 0; m_upd = 0;
    if (feed) begin m_cnt = m_period; m_upd = 1; end               // R2 R11
    else if (t && run) begin
      m_upd = 1;
      if (m_cnt <= 1) begin ex = 1; m_cnt = m_period; end          // R4
      else begin if (m_cnt == 2) wn = 1; m_cnt = m_cnt - 1; end    // R3 R5
    end
    if (w) begin
      case (a)
        8'h04: m_period = int'(d[14:0]);
        8'h0C: if (m_armed && d == 32'hCAFE) m_en = 0;              // R7
        8'h1C: if (d == 32'hACED) m_en = 1;                         // R8
        8'h10: if (d == 32'hE8B4) m_st = 0;                         // R9
        8'h20: if (d[0]) m_evt = 0;
        8'h24: m_mask = d[0];
        8'h28: m_force = d[0];
        8'h18: m_dbgrun = d[0];
        default: ;
      endcase
      m_armed = (a == 8'h08 && d == 32'h2BAD);
    end
    if (ex) m_st = 1;
    if (wn) m_evt = 1;
    m_rst = ex;
  endtask

  task automatic op(input bit t, input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    tick_i = t; bus_we_i = w; bus_addr_i = a; bus_wdata_i = d;
    model(t, w, a, d);
    @(negedge clk);
    tick_i = 0; bus_we_i = 0; bus_wdata_i = '0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(8'h14, v); check({tag, " R3 count"}, v, {16'h0, m_upd, 15'(m_cnt)});
    rd(8'h10, v); check({tag, " R9 status"}, v, m_st ? 32'hCFE8 : 32'h0);
    rd(8'h0C, v); check({tag, " R7 stopcode"}, v, m_en ? 32'h0 : 32'hDABE);
    rd(8'h20, v); check({tag, " R5 event"}, v, {31'h0, m_evt});
    check({tag, " R6 irq"}, {31'h0, warn_irq_o}, {31'h0, (m_evt & m_mask) | m_force});
    check({tag, " R4 rstpulse"}, {31'h0, wdt_rst_o}, {31'h0, m_rst});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1357));
    m_cnt = 6000; m_period = 6000; m_en = 1; m_armed = 0; m_st = 0; m_evt = 0;
    m_mask = 0; m_force = 0; m_dbgrun = 0; m_rst = 0; m_upd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h04, v); check("R1 period", v, 32'd6000);
    rd(8'h18, v); check("R1 debug", v, 32'h0);
    rd(8'h24, v); check("R1 mask", v, 32'h0);
    rd(8'h28, v); check("R1 force", v, 32'h0);
    check_all("R1");

    // R2 wrong key ignored, right key reloads
    op(1, 0, 8'h00, 0); op(0, 1, 8'h00, 32'hFEEE); check_all("R2 badkey");
    op(0, 1, 8'h00, 32'h1_FEED); check_all("R2 upperbits");
    op(0, 1, 8'h04, 32'd4); op(0, 1, 8'h00, 32'hFEED); check_all("R2 reload");

    // R3 R5 R4 countdown to expiry, warning one tick earlier
    op(0, 1, 8'h24, 1);
    for (int i = 0; i < 5; i++) begin op(1, 0, 8'h00, 0); check_all("R4 countdown"); end
    rd(8'h14, v); check("R3 stable bit15", v, {17'h0, 15'(m_cnt)});

    // R5 ack, R9 wrong and right clear
    op(0, 1, 8'h20, 1); check_all("R5 ack");
    op(0, 1, 8'h10, 32'hE8B5); check_all("R9 badclear");
    op(0, 1, 8'h10, 32'hE8B4); check_all("R9 clear");

    // R7 lone second key, interrupted sequence, proper stop
    op(0, 1, 8'h0C, 32'hCAFE); check_all("R7 lone");
    op(0, 1, 8'h08, 32'h2BAD); op(0, 1, 8'h24, 1); op(0, 1, 8'h0C, 32'hCAFE); check_all("R7 spoiled");
    op(0, 1, 8'h08, 32'h2BAD); op(0, 1, 8'h0C, 32'hCAFE); check_all("R7 stop");
    op(1, 0, 8'h00, 0); op(1, 0, 8'h00, 0); check_all("R7 frozen");
    op(0, 1, 8'h1C, 32'hACEE); check_all("R8 badresume");
    op(0, 1, 8'h1C, 32'hACED); check_all("R8 resume");

    // R11 reload in the same cycle as a tick
    op(0, 1, 8'h04, 32'd1); op(1, 1, 8'h00, 32'hFEED); check_all("R11 collide");

    // R10 debug freeze and debug-run
    dbg_mode_i = 1;
    rd(8'h18, v); check("R10 debug bit1", v, 32'h2);
    op(1, 0, 8'h00, 0); check_all("R10 freeze");
    op(0, 1, 8'h18, 1); op(1, 0, 8'h00, 0); check_all("R10 run");
    dbg_mode_i = 0;

    // R6 force
    op(0, 1, 8'h28, 1); check_all("R6 force");
    op(0, 1, 8'h28, 0); check_all("R6 unforce");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int   k;
      bit   t;
      logic [31:0] d;
      k = int'($urandom_range(0, 15));
      t = ($urandom_range(0, 2) != 0);
      d = 32'($urandom_range(0, 1));
      case (k)
        0: op(t, 1, 8'h00, 32'hFEED);
        1: op(t, 1, 8'h04, 32'($urandom_range(1, 6)));
        2: op(t, 1, 8'h08, 32'h2BAD);
        3: op(t, 1, 8'h0C, 32'hCAFE);
        4: op(t, 1, 8'h1C, 32'hACED);
        5: op(t, 1, 8'h10, 32'hE8B4);
        6: op(t, 1, 8'h20, d);
        7: op(t, 1, 8'h24, d);
        8: op(t, 1, 8'h28, ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h0);
        9: op(t, 1, 8'h18, d);
        10: begin dbg_mode_i = ($urandom_range(0, 3) == 0); op(t, 0, 8'h00, 0); end
        11: op(t, 1, 8'h00, 32'($urandom));
        default: op(t, 0, 8'h00, 0);
      endcase
      check_all("RND");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule